// File: doc/BRIEF.md
# Four-Channel DMA Address and Count Engine

This block is the bookkeeping core of a four-channel DMA controller on a simple processor bus. Each channel holds a base and a current address register and a base and a current word-count register, all 16 bits wide. Software sets these up, along with a per-channel mode, a shared command, a mask, a software request and a width register, through a small register port. A channel asks for service from its hardware request pin or from its software request bit. While its mask bit is set, neither source is seen.

When the command enable bit is set and at least one unmasked request is pending, the engine grants one channel. The priority order is either fixed or rotating. The granted channel's bus address is shown on `adr_lo` and `adr_hi`, and an `adstb` pulse in the first grant cycle lets an external latch capture the upper part. The grant is held until the bus side reports, with `xfer_ack`, that the transfer has completed. At that point the channel's address steps by one, up or down, and its count drops by one. The transfer in which the count goes from 0 to 0xFFFF raises end of process. After end of process, a channel in autoinitialize mode reloads its current registers from its base registers, and any other channel masks itself.

Every grant covers exactly one transfer. After each transfer the engine arbitrates again.

Top module: `dma_engine`

Register map (5-bit `reg_addr`):
- 0x00–0x07: channel registers. `reg_addr[2:1]` is the channel. `reg_addr[0]` selects the address (0) or the word count (1). A write loads both the base and the current register; a read returns the current value.
- 0x18–0x1F: the same layout, read-only, returning the base values.
- 0x08–0x0B: mode of channels 0–3, 6 bits. Bit 0 is decrement, bit 1 is autoinitialize, and bits 5:2 are kept as written.
- 0x0C: command, 8 bits. Bit 0 enables grants, bit 1 selects rotating priority, and bits 7:2 are kept as written.
- 0x0D: status, read-only. Bits 3:0 are the per-channel terminal-count flags, and bits 7:4 are the per-channel unmasked pending requests.
- 0x0E: mask, 4 bits.
- 0x0F: software request, 4 bits.
- 0x10: width, 4 bits. A 1 in a channel's bit makes that channel 16-bit.

## Requirements
- R1: After reset `dack`, `adstb` and `eop` are 0. The mask reads 0xF, and the command, status, width, software request, mode and channel registers read 0.
- R2: A write to a channel address or count register loads both the base and the current copy. A read at 0x00–0x07 returns the current value, and a read at 0x18–0x1F returns the base value.
- R3: A channel is pending when `dreq[i]` or software request bit i is 1 and mask bit i is 0. No grant is issued while command bit 0 is 0, and a masked channel is never granted.
- R4: A grant drives exactly one `dack` bit from the cycle after arbitration. It holds that bit unchanged until the cycle in which `xfer_ack` is 1, and `adstb` is 1 only in the first grant cycle.
- R5: On each acknowledged transfer the current address rises by 1 when mode bit 0 is 0 and falls by 1 when it is 1, wrapping within 16 bits.
- R6: The bus address `{adr_hi, adr_lo}` is the current address for an 8-bit channel and twice the current address for a 16-bit channel (width bit = 1). `xfer_wide` shows the granted channel's width bit.
- R7: Each acknowledged transfer decrements the current count. `eop` is 1 during the acknowledged transfer whose starting count is 0, after which the count reads 0xFFFF.
- R8: At end of process on a channel without autoinitialize, the channel's mask bit is set. At end of process on any channel, its software request bit is cleared.
- R9: At end of process on a channel with mode bit 1 set, the current address and count are reloaded from the base registers and the mask bit is left unchanged.
- R10: End of process sets the channel's status bit (bit i). A status read clears bits 3:0, and status bits 7:4 show the unmasked pending requests.
- R11: With command bit 1 equal to 0, the lowest-numbered pending channel is granted.
- R12: With command bit 1 equal to 1, the channel granted last becomes the lowest priority and the channel after it becomes the highest.
- R13: The mode, command, mask, width and software request registers read back what was written, apart from the changes that end of process makes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the flags) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| dreq | input | 4 | Hardware request per channel |
| dack | output | 4 | One-hot grant |
| xfer_ack | input | 1 | The granted transfer completes in this cycle |
| xfer_wide | output | 1 | The granted channel moves 16-bit words |
| adr_lo | output | 8 | Lower 8 bits of the bus address |
| adr_hi | output | 9 | Upper bits of the bus address, captured with `adstb` |
| adstb | output | 1 | Upper-address strobe in the first grant cycle |
| eop | output | 1 | End of process for the acknowledged transfer |

## Verification
The assertions check on every cycle that the grant is one-hot, that it stays steady until acknowledged, and that the strobe appears only in the first grant cycle. They also check that a channel masked at arbitration time is never granted, that `eop` appears only during an acknowledged grant, and that end of process always sets the terminal-count flag and, without autoinitialize, the mask. The bench scenarios are needed for the rest. These are the actual address and count sequences in both step directions and both widths, the underflow to 0xFFFF, and the reload from the base registers. They also cover the clear-on-read of status, the blocking effect of the enable bit, the removal of the software request, and the grant order under fixed and rotating priority.

// File: rtl/dma_pkg.sv
`timescale 1ns/100ps
package dma_pkg;

    localparam int WORD_W = 16;
    localparam int BUSA_W = WORD_W + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BUSA_W-1:0] busa_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       autoinit;
        logic       decr;
    } mode_t;

    typedef struct packed {
        logic [5:0] spare;
        logic       rotate;
        logic       enable;
    } cmd_t;

    // register map (5-bit address)
    localparam logic [1:0] PFX_CHAN   = 2'b00;
    localparam logic [1:0] PFX_BASE   = 2'b11;
    localparam logic [2:0] PFX_MODE   = 3'b010;
    localparam logic [4:0] ADR_CMD    = 5'h0C;
    localparam logic [4:0] ADR_STATUS = 5'h0D;
    localparam logic [4:0] ADR_MASK   = 5'h0E;
    localparam logic [4:0] ADR_SWREQ  = 5'h0F;
    localparam logic [4:0] ADR_WIDTH  = 5'h10;

    function automatic word_t step_addr(word_t a, logic decr);
        return decr ? a - word_t'(1) : a + word_t'(1);
    endfunction

    function automatic busa_t bus_addr(word_t a, logic wide);
        return wide ? {a, 1'b0} : {1'b0, a};
    endfunction

endpackage

// File: rtl/dma_chan.sv
`timescale 1ns/100ps
module dma_chan
    import dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_addr,
    input  logic  wr_cnt,
    input  word_t wdata,
    input  logic  step,
    input  logic  decr,
    input  logic  autoinit,
    output word_t cur_addr,
    output word_t cur_cnt,
    output word_t base_addr,
    output word_t base_cnt
);

    logic at_end;
    assign at_end = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            base_addr <= '0;
        end else if (wr_addr) begin
            cur_addr  <= wdata;
            base_addr <= wdata;
        end else if (step) begin
            cur_addr  <= (at_end && autoinit) ? base_addr : step_addr(cur_addr, decr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cnt  <= '0;
            base_cnt <= '0;
        end else if (wr_cnt) begin
            cur_cnt  <= wdata;
            base_cnt <= wdata;
        end else if (step) begin
            cur_cnt  <= (at_end && autoinit) ? base_cnt : cur_cnt - word_t'(1);
        end
    end

endmodule

// File: rtl/dma_arb.sv
`timescale 1ns/100ps
module dma_arb #(
    parameter int NCH = 4,
    localparam int CIW = $clog2(NCH)
) (
    input  logic [NCH-1:0] pend,
    input  logic           rotate,
    input  logic [CIW-1:0] top,
    output logic           any,
    output logic [CIW-1:0] win
);

    logic [CIW-1:0] idx;

    always_comb begin
        any = 1'b0;
        win = '0;
        idx = '0;
        for (int k = 0; k < NCH; k++) begin
            idx = rotate ? CIW'(int'(top) + k) : CIW'(k);
            if (!any && pend[idx]) begin
                any = 1'b1;
                win = idx;
            end
        end
    end

endmodule

// File: rtl/dma_engine.sv
`timescale 1ns/100ps
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CIW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [4:0]     reg_addr,
    input  logic [15:0]    reg_wdata,
    output logic [15:0]    reg_rdata,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    input  logic           xfer_ack,
    output logic           xfer_wide,
    output logic [7:0]     adr_lo,
    output logic [8:0]     adr_hi,
    output logic           adstb,
    output logic           eop
);

    word_t cur_a [NCH];
    word_t cur_c [NCH];
    word_t base_a[NCH];
    word_t base_c[NCH];
    mode_t mode_q[NCH];

    cmd_t           cmd_q;
    logic [NCH-1:0] mask_q, swreq_q, width_q, tc_q;
    logic [NCH-1:0] pend, eop_vec, eop_mask;
    logic           active, first_q;
    logic [CIW-1:0] gnt, top_q, win;
    logic           any, auto_sel, rd_status;
    busa_t          badr;

    assign pend      = (dreq | swreq_q) & ~mask_q;
    assign auto_sel  = mode_q[gnt].autoinit;
    assign eop       = active && xfer_ack && (cur_c[gnt] == '0);
    assign eop_vec   = eop ? (NCH'(1) << gnt) : '0;
    assign eop_mask  = auto_sel ? '0 : eop_vec;
    assign rd_status = reg_rd && (reg_addr == ADR_STATUS);

    dma_arb #(.NCH(NCH)) u_arb (
        .pend  (pend),
        .rotate(cmd_q.rotate),
        .top   (top_q),
        .any   (any),
        .win   (win)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_ch, wr_a, wr_c, stp;
        assign sel_ch = reg_wr && (reg_addr[4:3] == PFX_CHAN) && (reg_addr[2:1] == 2'(i));
        assign wr_a   = sel_ch && !reg_addr[0];
        assign wr_c   = sel_ch && reg_addr[0];
        assign stp    = active && xfer_ack && (gnt == CIW'(i)) && !sel_ch;

        dma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_addr  (wr_a),
            .wr_cnt   (wr_c),
            .wdata    (reg_wdata),
            .step     (stp),
            .decr     (mode_q[i].decr),
            .autoinit (mode_q[i].autoinit),
            .cur_addr (cur_a[i]),
            .cur_cnt  (cur_c[i]),
            .base_addr(base_a[i]),
            .base_cnt (base_c[i])
        );

        always_ff @(posedge clk) begin
            if (rst)
                mode_q[i] <= '0;
            else if (reg_wr && (reg_addr[4:2] == PFX_MODE) && (reg_addr[1:0] == 2'(i)))
                mode_q[i] <= mode_t'(reg_wdata[5:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            mask_q  <= '1;
            swreq_q <= '0;
            width_q <= '0;
            tc_q    <= '0;
            active  <= 1'b0;
            first_q <= 1'b0;
            gnt     <= '0;
            top_q   <= '0;
        end else begin
            first_q <= 1'b0;
            if (!active) begin
                if (cmd_q.enable && any) begin
                    active  <= 1'b1;
                    first_q <= 1'b1;
                    gnt     <= win;
                    top_q   <= win + CIW'(1);
                end
            end else if (xfer_ack) begin
                active <= 1'b0;
            end
            if (reg_wr && reg_addr == ADR_CMD)   cmd_q   <= cmd_t'(reg_wdata[7:0]);
            if (reg_wr && reg_addr == ADR_WIDTH) width_q <= reg_wdata[NCH-1:0];
            mask_q  <= ((reg_wr && reg_addr == ADR_MASK)  ? reg_wdata[NCH-1:0] : mask_q) | eop_mask;
            swreq_q <= ((reg_wr && reg_addr == ADR_SWREQ) ? reg_wdata[NCH-1:0] : swreq_q) & ~eop_vec;
            tc_q    <= (rd_status ? '0 : tc_q) | eop_vec;
        end
    end

    assign badr      = bus_addr(cur_a[gnt], width_q[gnt]);
    assign adr_lo    = badr[7:0];
    assign adr_hi    = badr[16:8];
    assign dack      = active ? (NCH'(1) << gnt) : '0;
    assign adstb     = first_q;
    assign xfer_wide = active && width_q[gnt];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[4:3] == PFX_CHAN)
            reg_rdata = reg_addr[0] ? cur_c[reg_addr[2:1]] : cur_a[reg_addr[2:1]];
        else if (reg_addr[4:3] == PFX_BASE)
            reg_rdata = reg_addr[0] ? base_c[reg_addr[2:1]] : base_a[reg_addr[2:1]];
        else if (reg_addr[4:2] == PFX_MODE)
            reg_rdata = {10'd0, mode_q[reg_addr[1:0]]};
        else begin
            case (reg_addr)
                ADR_CMD:    reg_rdata = {8'd0, cmd_q};
                ADR_STATUS: reg_rdata = 16'({pend, tc_q});
                ADR_MASK:   reg_rdata = 16'(mask_q);
                ADR_SWREQ:  reg_rdata = 16'(swreq_q);
                ADR_WIDTH:  reg_rdata = 16'(width_q);
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_engine_chk.sv
`timescale 1ns/100ps
module dma_engine_chk #(
    parameter int NCH = 4,
    localparam int CIW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dack,
    input logic           adstb,
    input logic           xfer_ack,
    input logic           eop,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] tc_q,
    input logic [CIW-1:0] gnt,
    input logic           auto_sel
);

    // R4
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dack));

    // R4
    dack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && !xfer_ack) |=> $stable(dack));

    // R4
    adstb_first_chk: assert property (@(posedge clk) disable iff (rst)
        adstb |-> $rose(|dack));

    // R3
    grant_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|dack) |-> (($past(mask_q) & dack) == '0));

    // R7
    eop_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
        eop |-> ((|dack) && xfer_ack));

    // R8
    eop_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (eop && !auto_sel) |=> mask_q[$past(gnt)]);

    // R10
    eop_tc_chk: assert property (@(posedge clk) disable iff (rst)
        eop |=> tc_q[$past(gnt)]);

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dack    (dack),
    .adstb   (adstb),
    .xfer_ack(xfer_ack),
    .eop     (eop),
    .mask_q  (mask_q),
    .tc_q    (tc_q),
    .gnt     (gnt),
    .auto_sel(auto_sel)
);

// File: tb/test_dma_engine.sv
`timescale 1ns/100ps
module test_dma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        xfer_ack = 1'b0;
    logic        xfer_wide;
    logic [7:0]  adr_lo;
    logic [8:0]  adr_hi;
    logic        adstb, eop;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_engine i_dma_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
        .xfer_ack(xfer_ack), .xfer_wide(xfer_wide), .adr_lo(adr_lo), .adr_hi(adr_hi),
        .adstb(adstb), .eop(eop)
    );

    typedef struct packed {
        logic [3:0]  dack;
        logic [16:0] adr;
        logic        eop;
        logic        wide;
    } item_t;
    item_t sb[$];

    // bench model of channel state
    logic [15:0] m_addr[4], m_cnt[4], m_ba[4], m_bc[4];
    bit          m_dec[4], m_auto[4], m_wide[4];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #0.5;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #0.5 d = reg_rdata;
        @(posedge clk); #0.5;
        reg_rd = 1'b0;
    endtask

    task automatic setup_ch(int ch, logic [15:0] a, logic [15:0] c, logic [5:0] mode);
        wr(5'(2*ch), a);
        wr(5'(2*ch+1), c);
        wr(5'(8+ch), 16'(mode));
        m_addr[ch] = a; m_ba[ch] = a; m_cnt[ch] = c; m_bc[ch] = c;
        m_dec[ch] = mode[0]; m_auto[ch] = mode[1];
    endtask

    // driver: push expected item from the model, then complete one transfer
    task automatic run_xfer(int ch);
        item_t it;
        it.dack = 4'(1 << ch);
        it.adr  = m_wide[ch] ? {m_addr[ch], 1'b0} : {1'b0, m_addr[ch]};
        it.eop  = (m_cnt[ch] == 16'h0);
        it.wide = m_wide[ch];
        sb.push_back(it);
        if (it.eop && m_auto[ch]) begin
            m_addr[ch] = m_ba[ch]; m_cnt[ch] = m_bc[ch];
        end else begin
            m_addr[ch] = m_dec[ch] ? m_addr[ch] - 16'd1 : m_addr[ch] + 16'd1;
            m_cnt[ch]  = m_cnt[ch] - 16'd1;
        end
        do @(negedge clk); while (dack == 4'h0);
        chk("R4 adstb in first grant cycle", 32'(adstb), 32'd1);
        xfer_ack = 1'b1;
        @(posedge clk); #0.5;
        xfer_ack = 1'b0;
    endtask

    // monitor: compare each acknowledged transfer against the scoreboard
    initial begin
        item_t exp;
        forever begin
            @(negedge clk); #0.5;
            if (xfer_ack && dack != 4'h0) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4 unexpected transfer actual=%h expected=none", dack);
                end else begin
                    exp = sb.pop_front();
                    chk("R11/R12 granted channel", 32'(dack), 32'(exp.dack));
                    chk("R5/R6 bus address", 32'({adr_hi, adr_lo}), 32'(exp.adr));
                    chk("R7 eop", 32'(eop), 32'(exp.eop));
                    chk("R6 xfer_wide", 32'(xfer_wide), 32'(exp.wide));
                end
            end
        end
    end

    task automatic idle_chk(string tag, int n);
        repeat (n) begin
            @(negedge clk);
            chk(tag, 32'(dack), 32'd0);
        end
    endtask

    initial begin
        logic [15:0] d;
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = '0; m_cnt[i] = '0; m_ba[i] = '0; m_bc[i] = '0;
            m_dec[i] = 0; m_auto[i] = 0; m_wide[i] = 0;
        end
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 dack", 32'(dack), 0);
        chk("R1 adstb/eop", 32'({adstb, eop}), 0);
        rd(5'h0E, d); chk("R1 mask", 32'(d), 32'hF);
        rd(5'h0C, d); chk("R1 command", 32'(d), 0);
        rd(5'h0D, d); chk("R1 status", 32'(d), 0);
        rd(5'h04, d); chk("R1 channel address", 32'(d), 0);

        // R2 load and read back
        setup_ch(0, 16'h1234, 16'h0002, 6'h00);
        rd(5'h00, d); chk("R2 current address", 32'(d), 32'h1234);
        rd(5'h01, d); chk("R2 current count", 32'(d), 32'h0002);
        rd(5'h18, d); chk("R2 base address", 32'(d), 32'h1234);
        rd(5'h19, d); chk("R2 base count", 32'(d), 32'h0002);

        // R3 enable off blocks grants
        wr(5'h0E, 16'hE);
        dreq = 4'b0001;
        idle_chk("R3 no grant while disabled", 4);
        rd(5'h0D, d); chk("R10 pending bit in status", 32'(d), 32'h10);
        wr(5'h0C, 16'h01);
        run_xfer(0); run_xfer(0); run_xfer(0);
        idle_chk("R8 masked after eop", 3);
        dreq = 4'b0000;
        rd(5'h0E, d); chk("R8 mask set after eop", 32'(d), 32'hF);
        rd(5'h00, d); chk("R5 address after three steps", 32'(d), 32'h1237);
        rd(5'h01, d); chk("R7 count underflow", 32'(d), 32'hFFFF);
        rd(5'h0D, d); chk("R10 terminal count flag", 32'(d), 32'h01);
        rd(5'h0D, d); chk("R10 flag cleared by read", 32'(d), 32'h00);

        // R9 autoinit, decrement, 16-bit, software request
        setup_ch(1, 16'h0100, 16'h0001, 6'h03);
        wr(5'h10, 16'h2); m_wide[1] = 1;
        wr(5'h0E, 16'hD);
        wr(5'h0F, 16'h2);
        run_xfer(1); run_xfer(1);
        idle_chk("R8 software request removed", 4);
        rd(5'h0F, d); chk("R8 software request cleared", 32'(d), 0);
        rd(5'h0E, d); chk("R9 mask unchanged", 32'(d), 32'hD);
        rd(5'h02, d); chk("R9 address reloaded", 32'(d), 32'h0100);
        rd(5'h03, d); chk("R9 count reloaded", 32'(d), 32'h0001);
        rd(5'h09, d); chk("R13 mode readback", 32'(d), 32'h03);
        rd(5'h10, d); chk("R13 width readback", 32'(d), 32'h2);
        rd(5'h0D, d); chk("R10 channel 1 flag", 32'(d), 32'h02);

        // R11 fixed priority, then R12 rotating
        setup_ch(2, 16'h2000, 16'h000A, 6'h00);
        setup_ch(3, 16'h3000, 16'h000A, 6'h00);
        wr(5'h0E, 16'h3);
        dreq = 4'b1100;
        run_xfer(2); run_xfer(2);
        dreq = 4'b0000;
        wr(5'h0C, 16'h03);
        rd(5'h0C, d); chk("R13 command readback", 32'(d), 32'h03);
        dreq = 4'b1100;
        run_xfer(3); run_xfer(2); run_xfer(3);
        dreq = 4'b0000;
        rd(5'h04, d); chk("R12 channel 2 address", 32'(d), 32'h2003);
        rd(5'h07, d); chk("R12 channel 3 count", 32'(d), 32'h0008);

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R4 missing transfers actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule